// File: doc/BRIEF.md
# Two-Way Cache Replacement Pointer with Evict-Next Hint

This block chooses the way to replace in a two-way set-associative data cache. It keeps one allocation pointer and two line-valid bits per set index. A lookup presents the set index, the per-way tag-match bits and a hint flag. The block answers one cycle later with a registered hit indication or, on a miss, a one-cycle allocate strobe and the chosen victim way. The fill logic outside then moves the line in and reports completion on a fill-done input. On that completion the block marks the victim way valid and updates the pointer of the set.

A miss without the hint is a plain allocation, and the pointer then moves to the way that was not filled, so the two ways are replaced in turn. A miss with the hint (evict-next) still allocates the line. The pointer is left on the way just filled, so the next miss at that index replaces the same block. A stream of hinted misses therefore cycles through one way and leaves the line in the other way alone. If a way of the set is still invalid, it is filled before the pointer is used.

The controller is a three-state machine. `ST_IDLE` accepts lookups. A miss takes it to `ST_ALLOC`, the cycle in which the allocate strobe is high. From `ST_ALLOC` a fill-done moves it back to `ST_IDLE`, and otherwise it goes to `ST_WAIT_FILL`. `ST_WAIT_FILL` stays until fill-done and then returns to `ST_IDLE`. A hit leaves the machine in `ST_IDLE`.

Top module: `evn_way_alloc`

## Requirements
- R1: After reset, `hit_o`, `alloc_o` and `victim_way_o` are 0, all pointers select way 0 and every line is invalid.
- R2: `hit_o` is 1 in the cycle after an accepted lookup exactly when some way has its `way_hit_i` bit set (bit 0 = way 0, bit 1 = way 1) and that way is valid. Otherwise it is 0.
- R3: An accepted lookup that misses raises `alloc_o` for exactly one cycle, in the cycle after the lookup, with `victim_way_o` giving the way to fill (0 = way 0, 1 = way 1). `victim_way_o` holds that value until the next miss.
- R4: If way 0 of the set is invalid it is the victim. Otherwise, if way 1 is invalid, way 1 is the victim. Only when both ways are valid does the set pointer choose.
- R5: When the fill of an unhinted miss completes, the pointer of that set selects the way that was not filled.
- R6: When the fill of a hinted miss completes, the pointer of that set selects the way that was just filled.
- R7: With both ways valid, any number of consecutive hinted misses at one index all replace the same way, and the line in the other way keeps hitting.
- R8: A hit changes neither the pointer nor the valid bits of any set.
- R9: While a fill is pending (from the allocate cycle until fill-done is taken), lookups are ignored: `hit_o` and `alloc_o` stay 0 and no state changes.
- R10: Fill-done marks the victim way of the pending set as valid, so a later lookup that matches that way hits.
- R11: A fill changes only the pointer and valid bits of its own set index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| lkp_valid_i | input | 1 | Lookup request this cycle |
| lkp_index_i | input | INDEX_W | Set index of the lookup |
| way_hit_i | input | 2 | Tag match per way (bit n = way n) |
| evict_hint_i | input | 1 | Lookup carries the evict-next hint |
| fill_done_i | input | 1 | Fill of the pending victim has completed |
| hit_o | output | 1 | Registered hit result |
| victim_way_o | output | 1 | Registered victim way of the last miss |
| alloc_o | output | 1 | One-cycle allocate strobe |

## Verification
The bench builds the block with `INDEX_W = 3`, so there are eight sets. That is small enough to drive every index through its full life: the two invalid-way fills, then a long, arithmetically varied mix of hits, hinted misses and plain misses. A per-set pointer and valid model in the bench predicts each result. With few sets, runs of hinted misses at one index, fills delayed by several cycles with lookups arriving meanwhile, and the effect of work at one index on its neighbours are all cheap to cover completely.

// File: rtl/evn_alloc_pkg.sv
`timescale 1ns/1ps
package evn_alloc_pkg;

    localparam int unsigned NUM_WAYS = 2;

    typedef logic [NUM_WAYS-1:0] way_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ALLOC     = 2'd1,
        ST_WAIT_FILL = 2'd2
    } alloc_state_e;

endpackage

// File: rtl/evn_set_state.sv
`timescale 1ns/1ps
module evn_set_state
    import evn_alloc_pkg::*;
#(
    parameter int unsigned INDEX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index_i,
    output logic               rd_ptr_o,
    output way_vec_t           rd_valid_o,
    input  logic               wr_en_i,
    input  logic [INDEX_W-1:0] wr_index_i,
    input  logic               wr_way_i,
    input  logic               wr_hint_i
);

    localparam int unsigned SETS = 1 << INDEX_W;

    logic [SETS-1:0]               ptr_flat;
    logic [SETS-1:0][NUM_WAYS-1:0] vld_flat;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic     ptr_q;
        way_vec_t vld_q;
        logic     sel;

        assign sel = wr_en_i && (wr_index_i == INDEX_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q <= 1'b0;
                vld_q <= '0;
            end else if (sel) begin
                vld_q[wr_way_i] <= 1'b1;
                ptr_q           <= wr_hint_i ? wr_way_i : ~wr_way_i;
            end
        end

        assign ptr_flat[s] = ptr_q;
        assign vld_flat[s] = vld_q;
    end

    assign rd_ptr_o   = ptr_flat[rd_index_i];
    assign rd_valid_o = vld_flat[rd_index_i];

    // R8 / R9: pointers move only on a fill commit
    a_r8_ptr_stable_without_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ptr_flat));

    // R10: a committed fill leaves its way valid
    a_r10_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> vld_flat[$past(wr_index_i)][$past(wr_way_i)]);

    // R9: valid bits change only on a fill commit
    a_r9_valid_stable_without_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(vld_flat));

endmodule

// File: rtl/evn_victim_pick.sv
`timescale 1ns/1ps
module evn_victim_pick
    import evn_alloc_pkg::*;
(
    input  way_vec_t valid_i,
    input  logic     ptr_i,
    output logic     victim_o
);

    always_comb begin
        if (!valid_i[0]) begin
            victim_o = 1'b0;
        end else if (!valid_i[1]) begin
            victim_o = 1'b1;
        end else begin
            victim_o = ptr_i;
        end
    end

endmodule

// File: rtl/evn_alloc_ctrl.sv
`timescale 1ns/1ps
module evn_alloc_ctrl
    import evn_alloc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lkp_valid_i,
    input  logic hit_any_i,
    input  logic fill_done_i,
    output logic open_o,
    output logic capture_o,
    output logic commit_o,
    output logic alloc_o
);

    alloc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        open_o    = 1'b0;
        capture_o = 1'b0;
        commit_o  = 1'b0;
        alloc_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                open_o = 1'b1;
                if (lkp_valid_i && !hit_any_i) begin
                    capture_o = 1'b1;
                    state_d   = ST_ALLOC;
                end
            end
            ST_ALLOC: begin
                alloc_o = 1'b1;
                if (fill_done_i) begin
                    commit_o = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d  = ST_WAIT_FILL;
                end
            end
            ST_WAIT_FILL: begin
                if (fill_done_i) begin
                    commit_o = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // R3: the allocate strobe lasts one cycle
    a_r3_alloc_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |=> !alloc_o);

    // R9: no new allocation while waiting for a fill
    a_r9_no_alloc_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_FILL) |=> !alloc_o);

endmodule

// File: rtl/evn_way_alloc.sv
`timescale 1ns/1ps
module evn_way_alloc
    import evn_alloc_pkg::*;
#(
    parameter int unsigned INDEX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid_i,
    input  logic [INDEX_W-1:0] lkp_index_i,
    input  logic [1:0]         way_hit_i,
    input  logic               evict_hint_i,
    input  logic               fill_done_i,
    output logic               hit_o,
    output logic               victim_way_o,
    output logic               alloc_o
);

    logic               rd_ptr;
    way_vec_t           rd_valid;
    logic               hit_any;
    logic               pick;
    logic               open_w, capture_w, commit_w;
    logic [INDEX_W-1:0] pend_index_q;
    logic               pend_hint_q;
    logic               victim_q;
    logic               hit_q;

    assign hit_any = |(way_hit_i & rd_valid);

    evn_set_state #(.INDEX_W(INDEX_W)) u_sets (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_index_i (lkp_index_i),
        .rd_ptr_o   (rd_ptr),
        .rd_valid_o (rd_valid),
        .wr_en_i    (commit_w),
        .wr_index_i (pend_index_q),
        .wr_way_i   (victim_q),
        .wr_hint_i  (pend_hint_q)
    );

    evn_victim_pick u_pick (
        .valid_i  (rd_valid),
        .ptr_i    (rd_ptr),
        .victim_o (pick)
    );

    evn_alloc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lkp_valid_i (lkp_valid_i),
        .hit_any_i   (hit_any),
        .fill_done_i (fill_done_i),
        .open_o      (open_w),
        .capture_o   (capture_w),
        .commit_o    (commit_w),
        .alloc_o     (alloc_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q        <= 1'b0;
            victim_q     <= 1'b0;
            pend_index_q <= '0;
            pend_hint_q  <= 1'b0;
        end else begin
            hit_q <= open_w && lkp_valid_i && hit_any;
            if (capture_w) begin
                victim_q     <= pick;
                pend_index_q <= lkp_index_i;
                pend_hint_q  <= evict_hint_i;
            end
        end
    end

    assign hit_o        = hit_q;
    assign victim_way_o = victim_q;

    // R2: a hit answer always follows a lookup
    a_r2_hit_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(lkp_valid_i));

    // R3: hit and allocate never coincide
    a_r3_hit_alloc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && alloc_o));

    // R3: the victim holds while its fill is pending
    a_r3_victim_held: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_o |=> $stable(victim_way_o));

endmodule

// File: tb/evn_way_alloc_tb.sv
`timescale 1ns/1ps
module evn_way_alloc_tb_top;

    localparam int unsigned IW   = 3;
    localparam int unsigned SETS = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lkp_valid = 1'b0;
    logic [IW-1:0] lkp_index = '0;
    logic [1:0]    way_hit = '0;
    logic          evict_hint = 1'b0;
    logic          fill_done = 1'b0;
    logic          hit_o, victim_way_o, alloc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_ptr [SETS];
    logic [1:0] m_vld [SETS];
    logic       m_lasthint [SETS];

    always #4 clk = ~clk;

    evn_way_alloc #(.INDEX_W(IW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lkp_valid_i  (lkp_valid),
        .lkp_index_i  (lkp_index),
        .way_hit_i    (way_hit),
        .evict_hint_i (evict_hint),
        .fill_done_i  (fill_done),
        .hit_o        (hit_o),
        .victim_way_o (victim_way_o),
        .alloc_o      (alloc_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One lookup; on a miss, fill after wait_cyc cycles, with optional
    // lookups probing the pending window (R9).
    task automatic lookup(input int idx, input logic [1:0] hv, input logic hint,
                          input int wait_cyc, input bit probe, input string tag_in);
        logic  exp_hit;
        logic  exp_vic;
        string tag;
        exp_hit = |(hv & m_vld[idx]);
        if (!m_vld[idx][0])      exp_vic = 1'b0;
        else if (!m_vld[idx][1]) exp_vic = 1'b1;
        else                     exp_vic = m_ptr[idx];
        if (tag_in != "")                     tag = tag_in;
        else if (exp_hit)                     tag = "R2";
        else if (m_vld[idx] != 2'b11)         tag = "R4";
        else if (m_lasthint[idx])             tag = "R7";
        else                                  tag = "R5";
        lkp_valid  = 1'b1;
        lkp_index  = IW'(idx);
        way_hit    = hv;
        evict_hint = hint;
        @(negedge clk);
        lkp_valid  = 1'b0;
        chk({tag, " hit"},   int'(hit_o),   int'(exp_hit));
        chk({tag, " alloc"}, int'(alloc_o), int'(!exp_hit));
        if (!exp_hit) begin
            chk({tag, " victim"}, int'(victim_way_o), int'(exp_vic));
            for (int w = 0; w < wait_cyc; w++) begin
                if (probe) begin
                    lkp_valid = 1'b1;
                    lkp_index = IW'(idx);
                    way_hit   = 2'b11;
                end
                @(negedge clk);
                lkp_valid = 1'b0;
                chk("R9 alloc while pending", int'(alloc_o), 0);
                if (probe) chk("R9 hit while pending", int'(hit_o), 0);
            end
            fill_done = 1'b1;
            @(negedge clk);
            fill_done = 1'b0;
            chk("R3 strobe ended", int'(alloc_o), 0);
            chk("R3 victim held", int'(victim_way_o), int'(exp_vic));
            m_vld[idx][exp_vic] = 1'b1;
            m_ptr[idx]          = hint ? exp_vic : ~exp_vic;
            m_lasthint[idx]     = hint;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SETS; i++) begin
            m_ptr[i] = 1'b0; m_vld[i] = 2'b00; m_lasthint[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        chk("R1 hit after reset",    int'(hit_o), 0);
        chk("R1 alloc after reset",  int'(alloc_o), 0);
        chk("R1 victim after reset", int'(victim_way_o), 0);

        // R1/R4: every set empty; matches must not hit, way 0 filled first
        for (int i = 0; i < SETS; i++) lookup(i, 2'b11, 1'b0, i % 3, 1'b0, "R1");
        // R4: way 1 invalid next
        for (int i = 0; i < SETS; i++) lookup(i, 2'b10, i[0], 0, 1'b0, "R4");
        // R10: filled ways now hit
        for (int i = 0; i < SETS; i++) begin
            lookup(i, 2'b01, 1'b0, 0, 1'b0, "R10");
            lookup(i, 2'b10, 1'b0, 0, 1'b0, "R10");
        end

        // Sweep: mixed hits, hinted and plain misses on every set
        for (int step = 0; step < 24; step++) begin
            for (int i = 0; i < SETS; i++) begin
                logic [1:0] hv;
                logic       hn;
                hv = 2'((i + step * 3) % 4);
                if ((i + step) % 5 == 0) hv = 2'b00;
                hn = ((i * 3 + step) % 3) == 0;
                lookup(i, hv, hn, (i + step) % 3, 1'b0, "");
            end
        end

        // R6/R7: long run of hinted misses at set 2 hits one way only
        lookup(2, 2'b00, 1'b1, 0, 1'b0, "R6");
        for (int k = 0; k < 6; k++) lookup(2, 2'b00, 1'b1, k % 2, 1'b0, "R7");
        lookup(2, m_ptr[2] ? 2'b01 : 2'b10, 1'b0, 0, 1'b0, "R7 other way kept");

        // R8: hits do not move the pointer
        for (int k = 0; k < 4; k++) lookup(3, 2'b11, 1'b0, 0, 1'b0, "R8");
        lookup(3, 2'b00, 1'b0, 0, 1'b0, "R8 pointer after hits");

        // R9: lookups during a pending fill are ignored
        lookup(4, 2'b00, 1'b0, 4, 1'b1, "R9");
        lookup(4, 2'b00, 1'b1, 3, 1'b1, "R9");
        lookup(4, 2'b00, 1'b0, 0, 1'b0, "R9 state after probes");

        // R11: heavy traffic at set 6 leaves set 5 alone
        lookup(5, 2'b00, 1'b0, 0, 1'b0, "R11");
        for (int k = 0; k < 5; k++) lookup(6, 2'b00, k[0], 0, 1'b0, "R11");
        lookup(5, 2'b00, 1'b0, 0, 1'b0, "R11 neighbour pointer");
        lookup(5, 2'b00, 1'b1, 0, 1'b0, "R11 neighbour pointer");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule